// File: doc/BRIEF.md
# Two-Wire Memory Slave with Clock Preamble

This block is the slave end of a two-wire serial link made of an active-low chip select and one shared data line. The link has no separate clock wire. The slave runs from its own local clock, and each time it is selected it announces that clock on the data line as a short toggling preamble. The master locks onto the preamble and then exchanges bits at exactly one bit per slave clock cycle.

After the preamble there is one idle cycle. The slave then takes in an 18-bit frame: a 2-bit opcode, an 8-bit address and an 8-bit data byte, each sent most significant bit first. Opcode 00 stores the byte in a 256 x 8 array. Opcode 01 reads the array. For a read, the slave waits one idle cycle and then sends back a frame that repeats the opcode, repeats the address, and ends with the stored byte. Opcodes 10 and 11 do nothing. Deselecting the slave at any moment ends the transaction.

The data line is split at the block edge into an input, an output value and an output enable. A pad or the surrounding logic combines them into the shared wire.

Top module: `twl_mem_slave`

## Requirements
- R1: In the first clock cycle after chip select is sampled low, the slave drives the data line. It drives for exactly 8 cycles with the pattern 1,0,1,0,1,0,1,0.
- R2: After the preamble, the line is released for one cycle. The next 18 cycles each sample one input bit: opcode (2 bits), then address (8 bits), then data (8 bits), each most significant bit first. The slave does not drive the line while it receives.
- R3: Opcode 00 stores the received data byte at the received address once the 18th bit has been sampled.
- R4: For opcode 01, the line stays released for one cycle after the 18th bit. The slave then drives 18 bits: 0, 1, the 8 address bits, then the 8 stored data bits, each field most significant bit first. After that the line is released.
- R5: A read ignores its data byte and leaves the array unchanged.
- R6: Opcodes 10 and 11 neither change the array nor produce any response on the line.
- R7: After reset, every location reads as 0x00 and the data line is released.
- R8: Chip select high releases the line in the same cycle and returns the slave to idle. A frame cut off before its 18th bit never writes the array. The next selection starts again with a full preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local slave clock; the link's bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the master |
| sd_in | input | 1 | Value seen on the shared data line |
| sd_out | output | 1 | Value the slave drives on the data line |
| sd_oe | output | 1 | High while the slave owns the data line |

## Verification
The hardest case to reach from the ports is a frame abandoned one bit short of completion. In that case the write decision sits only one sampling edge away. The bench raises chip select just before the 18th bit, and also at an earlier bit. It then proves, with a later full read of the same address, that the array kept its previous value. It also checks that the following selection restarts from a fresh preamble. A full write sweep of all 256 addresses is followed by a read sweep that sends inverted data bytes. Together these cover every address bit and every data bit in both directions.

// File: rtl/twl_mem_slave.sv
module twl_mem_slave #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int PRE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sd_in,
  output logic sd_out,
  output logic sd_oe
);
  localparam int OP_W    = 2;
  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CNT_MAX = (FRAME_W > PRE_LEN) ? FRAME_W : PRE_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PRE_END   = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_W - 1);
  localparam logic [OP_W-1:0]  OP_WRITE  = 2'b00;
  localparam logic [OP_W-1:0]  OP_READ   = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_TA_IN, S_RX, S_TA_OUT, S_TX, S_HOLD
  } state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic [DATA_W-1:0]  mem [DEPTH];

  wire [FRAME_W-1:0] frame   = {sh[FRAME_W-2:0], sd_in};
  wire [OP_W-1:0]    f_op    = frame[FRAME_W-1 -: OP_W];
  wire [ADDR_W-1:0]  f_addr  = frame[DATA_W +: ADDR_W];
  wire [DATA_W-1:0]  f_data  = frame[DATA_W-1:0];
  wire [ADDR_W-1:0]  rd_addr = sh[DATA_W +: ADDR_W];
  wire               rx_last = (st == S_RX) && (cnt == FRAME_END);
  wire               wr_en   = rx_last && !cs_n && (f_op == OP_WRITE);

  assign sd_oe  = !cs_n && (st == S_PRE || st == S_TX);
  assign sd_out = sd_oe && ((st == S_PRE) ? ~cnt[0] : sh[FRAME_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      sh  <= '0;
    end else if (cs_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st  <= S_PRE;
          cnt <= '0;
        end
        S_PRE: begin
          if (cnt == PRE_END) begin
            st  <= S_TA_IN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TA_IN: begin
          st  <= S_RX;
          cnt <= '0;
        end
        S_RX: begin
          sh <= frame;
          if (rx_last) begin
            cnt <= '0;
            st  <= (f_op == OP_READ) ? S_TA_OUT : S_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TA_OUT: begin
          sh  <= {OP_READ, rd_addr, mem[rd_addr]};
          st  <= S_TX;
          cnt <= '0;
        end
        S_TX: begin
          sh <= {sh[FRAME_W-2:0], 1'b0};
          if (cnt == FRAME_END) begin
            st  <= S_HOLD;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[f_addr] <= f_data;
    end
  end
endmodule

// File: rtl/twl_mem_slave_chk.sv
module twl_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sd_out,
  input logic sd_oe
);
  logic cs_q, cs_q2, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      cs_q2 <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      cs_q2 <= cs_q;
      oe_q  <= sd_oe;
    end
  end

  assert_preamble_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_q) ##1 !cs_n |-> (sd_oe && sd_out));

  assert_turnaround_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !sd_oe && !cs_n) |=> !sd_oe);

  assert_resp_header_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && !oe_q && !cs_q2) |-> !sd_out);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sd_oe);
endmodule

bind twl_mem_slave twl_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sd_out(sd_out), .sd_oe(sd_oe)
);

// File: tb/twl_mem_slave_test.sv
module twl_mem_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sd_in = 1'b0;
  logic sd_out, sd_oe;
  int   n_run = 0;
  int   n_fail = 0;

  twl_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sd_in(sd_in),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // abort_at: index of the frame bit before which chip select is raised (-1: none)
  task automatic xfer(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                      input int abort_at, output logic [7:0] rdata);
    logic [17:0] f;
    logic [17:0] resp;
    f = {op, a, d};
    resp = '0;
    rdata = '0;
    @(negedge clk);
    cs_n = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step();
      check(sd_oe === 1'b1, "R1 preamble oe", int'(sd_oe), 1);
      check(sd_out === ((k % 2) == 0), "R1 preamble bit", int'(sd_out), int'((k % 2) == 0));
    end
    step();
    check(sd_oe === 1'b0, "R2 turnaround after preamble", int'(sd_oe), 0);
    step();
    for (int b = 0; b < 18; b++) begin
      if (b == abort_at) begin
        cs_n = 1'b1;
        #1;
        check(sd_oe === 1'b0, "R8 release on abort", int'(sd_oe), 0);
        step();
        check(sd_oe === 1'b0, "R8 idle after abort", int'(sd_oe), 0);
        return;
      end
      sd_in = f[17-b];
      check(sd_oe === 1'b0, "R2 line released in receive", int'(sd_oe), 0);
      if (b < 17) step();
    end
    step();
    sd_in = 1'b0;
    check(sd_oe === 1'b0, "R4 turnaround before response", int'(sd_oe), 0);
    if (op == 2'b01) begin
      step();
      for (int b = 0; b < 18; b++) begin
        check(sd_oe === 1'b1, "R4 response oe", int'(sd_oe), 1);
        resp[17-b] = sd_out;
        step();
      end
      check(sd_oe === 1'b0, "R4 release after response", int'(sd_oe), 0);
      check(resp[17:8] === {2'b01, a}, "R4 response header", int'(resp[17:8]), int'({2'b01, a}));
      rdata = resp[7:0];
    end else begin
      for (int k = 0; k < 22; k++) begin
        step();
        check(sd_oe === 1'b0, (op == 2'b00) ? "R3 no response to write" : "R6 no response",
              int'(sd_oe), 0);
      end
    end
    cs_n = 1'b1;
    #1;
    check(sd_oe === 1'b0, "R8 release on deselect", int'(sd_oe), 0);
    step();
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 73 + 29) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check(sd_oe === 1'b0, "R7 released in reset", int'(sd_oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sd_oe === 1'b0, "R7 released after reset", int'(sd_oe), 0);

    xfer(2'b01, 8'h00, 8'hFF, -1, rd);
    check(rd === 8'h00, "R7 zero at 00", int'(rd), 0);
    xfer(2'b01, 8'hCE, 8'h56, -1, rd);
    check(rd === 8'h00, "R7 zero at CE", int'(rd), 0);
    xfer(2'b01, 8'hFF, 8'hA5, -1, rd);
    check(rd === 8'h00, "R7 zero at FF", int'(rd), 0);

    for (int a = 0; a < 256; a++) xfer(2'b00, 8'(a), pat(a), -1, rd);
    for (int a = 0; a < 256; a++) begin
      xfer(2'b01, 8'(a), ~pat(a), -1, rd);
      check(rd === pat(a), "R3 write then read", int'(rd), int'(pat(a)));
    end
    for (int a = 0; a < 256; a += 17) begin
      xfer(2'b01, 8'(a), 8'h00, -1, rd);
      check(rd === pat(a), "R5 read left data intact", int'(rd), int'(pat(a)));
    end

    xfer(2'b10, 8'h05, 8'hAA, -1, rd);
    xfer(2'b11, 8'h06, 8'h55, -1, rd);
    xfer(2'b01, 8'h05, 8'h00, -1, rd);
    check(rd === pat(5), "R6 opcode 10 no write", int'(rd), int'(pat(5)));
    xfer(2'b01, 8'h06, 8'h00, -1, rd);
    check(rd === pat(6), "R6 opcode 11 no write", int'(rd), int'(pat(6)));

    xfer(2'b00, 8'h07, 8'h3C, 17, rd);
    xfer(2'b01, 8'h07, 8'h00, -1, rd);
    check(rd === pat(7), "R8 abort before last bit", int'(rd), int'(pat(7)));
    xfer(2'b00, 8'h08, 8'hC3, 10, rd);
    xfer(2'b01, 8'h08, 8'h00, -1, rd);
    check(rd === pat(8), "R8 abort mid address", int'(rd), int'(pat(8)));

    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) step();
    check(sd_oe === 1'b1, "R1 driving mid preamble", int'(sd_oe), 1);
    cs_n = 1'b1;
    #1;
    check(sd_oe === 1'b0, "R8 release mid preamble", int'(sd_oe), 0);
    step();
    xfer(2'b00, 8'hCE, 8'h56, -1, rd);
    xfer(2'b01, 8'hCE, 8'h00, -1, rd);
    check(rd === 8'h56, "R8 restart after preamble abort", int'(rd), 8'h56);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule